// File: doc/BRIEF.md
# Carry-Pipelined Phase Accumulator with Strobed Word Loading

This block is the phase engine of a numerically controlled oscillator. A 32-bit tuning word is added to a running phase on every sample clock. The adder is cut into four 8-bit sections. Each section registers its own sum and passes its carry to the section above one clock later, so the longest combinational path is one 8-bit add. The top section is the phase output: an 8-bit value, with a square-wave sine and a quadrature square-wave cosine taken from its two highest bits.

Software, or a bus master, places a tuning word on the data bus and pulses an active-low write strobe. That strobe need not be related to the sample clock. The word is captured on the strobe's rising edge. The strobe is then brought into the sample-clock domain, and the new word is released into the pipeline one byte at a time, least significant byte first, one byte per clock. Each byte therefore arrives at its adder section in the same cycle as the carries that belong to it. As a result the top byte behaves exactly like the top byte of an ideal, non-pipelined 32-bit accumulator, delayed by three clocks, including across changes of the tuning word.

Top module: `ncoacc_top`

## Requirements
- R1: A tuning word is captured from `freq_bus` only on the rising edge of `wr_n`. Bus values that are present while `wr_n` stays low, or while it stays high, have no effect.
- R2: `wr_n` is passed through two synchronizing flops, and each rising edge of the synchronized strobe produces exactly one single-cycle load pulse. When `wr_n` rises between clock edges, byte 0 of the new word is adopted on the fourth rising clock edge after that rise.
- R3: Byte k of the new word (bits 8k+7..8k) is adopted exactly one clock after byte k-1, for k = 1..3.
- R4: A byte lane of the active tuning word changes only in the cycle after its own load pulse.
- R5: After clock edge t, `phase` equals bits 31..24 of an ideal 32-bit accumulator as it stood after edge t-3. The ideal accumulator adds, on every edge, the tuning word whose byte 0 has been adopted. This holds across word changes, with no step that differs from the ideal.
- R6: The phase wraps modulo 2^32. The word 0xFFFFFFFF acts as a step of -1 LSB and 0x80000000 as a half turn.
- R7: `sin_sq` equals `phase[7]`, and `cos_sq` equals NOT(`phase[7]` XOR `phase[6]`), so the two are a quarter cycle apart.
- R8: With `rst` high at a clock edge, the tuning word lanes, the internal carries and `phase` are cleared. After that edge `phase` = 0, `sin_sq` = 0 and `cos_sq` = 1.
- R9: Once a zero tuning word has fully propagated and the carries are drained, `phase` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe, asynchronous to `clk` |
| freq_bus | input | 32 | Tuning word data bus |
| phase | output | 8 | Top 8 bits of the pipelined phase |
| sin_sq | output | 1 | Square-wave sine |
| cos_sq | output | 1 | Square-wave cosine in quadrature |

## Verification
The assertions check the following on every cycle:
- the reset clearing;
- that each synchronized strobe rise yields one load pulse and never two in a row;
- that every byte lane holds its value outside its own load pulse;
- that the phase stays frozen while the word and the carries are zero.

Some behaviour is visible only in the bench scenarios:
- the end-to-end equivalence to an ideal 32-bit accumulator over many words;
- the exact four-clock adoption latency;
- the seamless joins where one word replaces another;
- wrap-around with extreme words;
- the quadrature outputs.

These are checked cycle by cycle against the bench's own reference model.

// File: rtl/ncoacc_pkg.sv
package ncoacc_pkg;

    parameter int LANE_W_DEF = 8;
    parameter int LANES_DEF  = 4;

    typedef struct packed {
        logic sin_sq;
        logic cos_sq;
    } quad_t;

    // Square quadrature pair from the two top phase bits.
    function automatic quad_t quad_of(input logic top_bit, input logic next_bit);
        quad_t q;
        q.sin_sq = top_bit;
        q.cos_sq = ~(top_bit ^ next_bit);
        return q;
    endfunction

endpackage

// File: rtl/ncoacc_strobe_sync.sv
module ncoacc_strobe_sync #(
    parameter int STAGES = ncoacc_pkg::LANES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    output logic              sync_q,
    output logic [STAGES-1:0] load
);

    logic meta_q;
    logic sync_d_q;

    // Idle level of the strobe is high, so reset to high to avoid a false pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= 1'b1;
            sync_q   <= 1'b1;
            sync_d_q <= 1'b1;
        end else begin
            meta_q   <= wr_n;
            sync_q   <= meta_q;
            sync_d_q <= sync_q;
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic pulse_q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pulse_q <= 1'b0;
                else     pulse_q <= sync_q & ~sync_d_q;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pulse_q <= 1'b0;
                else     pulse_q <= load[s-1];
            end
        end
        assign load[s] = pulse_q;
    end

endmodule

// File: rtl/ncoacc_word_loader.sv
module ncoacc_word_loader #(
    parameter int LANE_W = ncoacc_pkg::LANE_W_DEF,
    parameter int LANES  = ncoacc_pkg::LANES_DEF,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_n,
    input  logic [WORD_W-1:0]            bus,
    input  logic [LANES-1:0]             load,
    output logic [LANES-1:0][LANE_W-1:0] fw
);

    logic [WORD_W-1:0] hold_q;

    // Capture in the strobe's own domain; stable long before any lane reads it.
    always_ff @(posedge wr_n) begin
        hold_q <= bus;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)          lane_q <= '0;
            else if (load[l]) lane_q <= hold_q[l*LANE_W +: LANE_W];
        end
        assign fw[l] = lane_q;
    end

endmodule

// File: rtl/ncoacc_pipe_acc.sv
module ncoacc_pipe_acc #(
    parameter int LANE_W = ncoacc_pkg::LANE_W_DEF,
    parameter int LANES  = ncoacc_pkg::LANES_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LANES-1:0][LANE_W-1:0] fw,
    output logic [LANES-1:0][LANE_W-1:0] sec,
    output logic [LANES-2:0]             cy
);

    for (genvar i = 0; i < LANES; i++) begin : g_sec
        logic              cin;
        logic [LANE_W-1:0] sum_q;

        if (i == 0) begin : g_cin0
            assign cin = 1'b0;
        end else begin : g_cinn
            assign cin = cy[i-1];
        end

        if (i < LANES - 1) begin : g_low
            logic [LANE_W:0] ext;
            logic            cy_q;
            always_comb ext = {1'b0, sum_q} + {1'b0, fw[i]} + {{LANE_W{1'b0}}, cin};
            always_ff @(posedge clk) begin
                if (rst) begin
                    sum_q <= '0;
                    cy_q  <= 1'b0;
                end else begin
                    sum_q <= ext[LANE_W-1:0];
                    cy_q  <= ext[LANE_W];
                end
            end
            assign cy[i] = cy_q;
        end else begin : g_top
            // Carry out of the top section is the turn count and is dropped.
            always_ff @(posedge clk) begin
                if (rst) sum_q <= '0;
                else     sum_q <= sum_q + fw[i] + {{(LANE_W-1){1'b0}}, cin};
            end
        end

        assign sec[i] = sum_q;
    end

endmodule

// File: rtl/ncoacc_top.sv
module ncoacc_top #(
    parameter int LANE_W = ncoacc_pkg::LANE_W_DEF,
    parameter int LANES  = ncoacc_pkg::LANES_DEF,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic [WORD_W-1:0] freq_bus,
    output logic [LANE_W-1:0] phase,
    output logic              sin_sq,
    output logic              cos_sq
);

    logic                         sync_lvl;
    logic [LANES-1:0]             load_vec;
    logic [LANES-1:0][LANE_W-1:0] fw_lanes;
    logic [LANES-1:0][LANE_W-1:0] sec;
    logic [LANES-2:0]             carries;
    ncoacc_pkg::quad_t            quad;

    ncoacc_strobe_sync #(.STAGES(LANES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .wr_n   (wr_n),
        .sync_q (sync_lvl),
        .load   (load_vec)
    );

    ncoacc_word_loader #(.LANE_W(LANE_W), .LANES(LANES)) u_load (
        .clk  (clk),
        .rst  (rst),
        .wr_n (wr_n),
        .bus  (freq_bus),
        .load (load_vec),
        .fw   (fw_lanes)
    );

    ncoacc_pipe_acc #(.LANE_W(LANE_W), .LANES(LANES)) u_acc (
        .clk (clk),
        .rst (rst),
        .fw  (fw_lanes),
        .sec (sec),
        .cy  (carries)
    );

    assign phase  = sec[LANES-1];
    assign quad   = ncoacc_pkg::quad_of(phase[LANE_W-1], phase[LANE_W-2]);
    assign sin_sq = quad.sin_sq;
    assign cos_sq = quad.cos_sq;

endmodule

// File: rtl/ncoacc_chk.sv
module ncoacc_chk #(
    parameter int LANE_W = ncoacc_pkg::LANE_W_DEF,
    parameter int LANES  = ncoacc_pkg::LANES_DEF
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         sync_lvl,
    input logic [LANES-1:0]             load,
    input logic [LANES-1:0][LANE_W-1:0] fw,
    input logic [LANE_W-1:0]            phase,
    input logic [LANES-2:0]             carry
);

    // R8: reset clears word lanes, carries and phase
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (phase == '0 && carry == '0 && fw == '0));

    // R2: a synchronized rise yields a load pulse on the next cycle
    a_r2_rise_loads: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_lvl) |=> load[0]);

    // R2: the load pulse lasts a single cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        load[0] |=> !load[0]);

    // R9: zero word with drained carries freezes the phase
    a_r9_zero_freeze: assert property (@(posedge clk) disable iff (rst)
        (fw == '0 && carry == '0) |=> $stable(phase));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // R4: a lane changes only after its own load pulse
        a_r4_lane_hold: assert property (@(posedge clk) disable iff (rst)
            !load[l] |=> $stable(fw[l]));
    end

endmodule

bind ncoacc_top ncoacc_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_lvl (sync_lvl),
    .load     (load_vec),
    .fw       (fw_lanes),
    .phase    (phase),
    .carry    (carries)
);

// File: tb/ncoacc_top_tb.sv
`timescale 1ns/100ps
module ncoacc_top_tb;

    localparam int NVEC = 8;
    localparam logic [31:0] VEC_WORD [NVEC] = '{
        32'h0100_0000, 32'h0080_0000, 32'h1234_5678, 32'h00FF_FFFF,
        32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'h4000_0000
    };
    localparam int VEC_RUN [NVEC] = '{60, 60, 80, 80, 60, 20, 40, 30};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_n = 1'b1;
    logic [31:0] freq_bus = '0;
    logic [7:0]  phase;
    logic        sin_sq, cos_sq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_ref, m_cur, m_pend;
    logic [31:0] m_hist [4];
    int          m_cnt = -1;

    always #2 clk = ~clk;

    ncoacc_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr_n     (wr_n),
        .freq_bus (freq_bus),
        .phase    (phase),
        .sin_sq   (sin_sq),
        .cos_sq   (cos_sq)
    );

    task automatic model_clear();
        m_ref = '0; m_cur = '0; m_cnt = -1;
        for (int k = 0; k < 4; k++) m_hist[k] = '0;
    endtask

    // One clock edge; inputs and samples sit 1 ns after the edge.
    task automatic step();
        @(posedge clk);
        #1;
        if (rst) begin
            model_clear();
        end else begin
            m_ref = m_ref + m_cur;
            for (int k = 3; k > 0; k--) m_hist[k] = m_hist[k-1];
            m_hist[0] = m_ref;
            if (m_cnt >= 0) begin
                m_cnt++;
                if (m_cnt == 4) begin
                    m_cur = m_pend;
                    m_cnt = -1;
                end
            end
        end
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_model(input string tag);
        logic [7:0] e;
        e = m_hist[3][31:24];
        check({tag, " R5 phase"}, phase, e);
        check("R7 quadrature", {6'd0, sin_sq, cos_sq}, {6'd0, e[7], ~(e[7] ^ e[6])});
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            step();
            check_model(tag);
        end
    endtask

    task automatic strobe(input logic [31:0] w);
        freq_bus = w;
        wr_n = 1'b0;
        step();
        check_model("strobe");
        wr_n = 1'b1;
        m_pend = w;
        m_cnt = 0;
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] held;
        int first;
        model_clear();
        for (int k = 0; k < 3; k++) step();
        check("R8 reset phase", phase, 8'h00);
        check("R8 reset sin/cos", {6'd0, sin_sq, cos_sq}, 8'h01);
        rst = 1'b0;

        // R2 R3: count edges until the top byte first moves
        strobe(32'h0100_0000);
        first = -1;
        for (int k = 1; k <= 12; k++) begin
            step();
            check_model("R2 R3 latency");
            if (first < 0 && phase != 8'h00) first = k;
        end
        check("R2 R3 first move edge", first[7:0], 8'd8);

        // Vector table: successive words, checked on every cycle (R5 R6)
        for (int v = 0; v < NVEC; v++) begin
            strobe(VEC_WORD[v]);
            run(VEC_RUN[v], "R5 R6 vector");
        end

        // R4: bus changes with strobe idle high have no effect
        freq_bus = 32'hDEAD_BEEF;
        run(20, "R4 idle bus");
        // R1: strobe held low, bus wandering, no capture until the rise
        wr_n = 1'b0;
        run(10, "R1 low hold");
        freq_bus = 32'h0333_3333;
        run(10, "R1 low hold");
        freq_bus = 32'h0200_0000;
        #1 wr_n = 1'b1;
        m_pend = 32'h0200_0000; m_cnt = 0;
        #1 freq_bus = 32'h7777_7777;
        run(40, "R1 capture on rise");

        // R9: zero word freezes the phase
        strobe(32'h0000_0000);
        run(12, "R9 settle");
        held = phase;
        for (int k = 0; k < 20; k++) begin
            step();
            check("R9 frozen phase", phase, held);
        end

        // R8: reset in mid-run with a word loaded
        strobe(32'h0ABC_DEF1);
        run(30, "R8 pre");
        rst = 1'b1;
        step();
        check("R8 mid-run phase", phase, 8'h00);
        check("R8 mid-run sin/cos", {6'd0, sin_sq, cos_sq}, 8'h01);
        step();
        rst = 1'b0;
        run(10, "R8 post zero word");
        check("R8 word cleared", phase, 8'h00);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule